// File: doc/BRIEF.md
# Hypervisor Storage Fault Reporter

This block sits after the partition-stage (guest real to host real) address translation. When that stage faults, it records the fault as hypervisor storage interrupt state. Each fault is sorted into one of two kinds. An instruction fetch fault becomes an instruction-kind exception. A load or store fault becomes a data-kind exception. The two kinds update different registers.

The cause word is adjusted before it is recorded. A store access sets a store indication bit. A fault raised while reading a guest table entry sets a table-access bit. On an instruction fault the adjusted cause also appears as an error code, and that error code is ORed into the machine-state value that is saved with the exception.

A capture enable lets a translation probe run without leaving any trace. Vectoring and delivery of the interrupt happen elsewhere.

Top module: `hvf_fault_capture`

## Requirements
- R1: A synchronous reset clears every output register to zero: kind, status, data address, secondary address, error code, saved state and event pulse.
- R2: A captured fault with access code 2'b10 (fetch) sets kind to 2'b01 (instruction) and loads the secondary address with the guest real address. The status and data address registers keep their values.
- R3: On a captured fetch fault, the error code becomes the adjusted cause. The saved state becomes the state input ORed with the zero-extended error code.
- R4: A captured fault with access code 2'b00 (read), 2'b01 (write) or 2'b11 (treated as read) sets kind to 2'b10 (data). It loads the status register with the adjusted cause, the data address register with the effective address, and the secondary address with the guest real address.
- R5: On a write access, bit 25 (0x02000000) is ORed into the recorded status. Read and fetch accesses add nothing at that bit.
- R6: When the table-access flag is set, bit 17 (0x00020000) is ORed into the recorded cause, for both kinds.
- R7: On a captured data fault, the error code becomes zero and the saved state becomes the unmodified state input.
- R8: In a cycle without a fault strobe, every register holds its value.
- R9: A fault strobe while the capture enable is low changes no register and raises no event pulse.
- R10: The event output is high for exactly the one cycle that follows each captured fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Capture enable; low for probe translations |
| flt_valid | input | 1 | Partition-stage fault strobe |
| acc_kind | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 read |
| eff_addr | input | ADDR_W | Effective address of the access |
| guest_ra | input | ADDR_W | Guest real address that failed to translate |
| cause_in | input | CAUSE_W | Raw fault cause word |
| tbl_walk | input | 1 | Fault occurred on a guest table-entry address |
| state_in | input | STATE_W | Machine-state value to be saved |
| exc_kind | output | 2 | 00 none, 01 instruction, 10 data |
| flt_status | output | CAUSE_W | Hypervisor data fault status |
| flt_daddr | output | ADDR_W | Hypervisor fault data address |
| sec_addr | output | ADDR_W | Secondary (guest real) address |
| err_code | output | CAUSE_W | Error code, non-zero only for instruction faults |
| saved_state | output | STATE_W | Machine state with the error code folded in |
| fault_evt | output | 1 | One-cycle pulse after each captured fault |

## Verification
The assertions assume that the access type, addresses, cause, table flag and state inputs carry known values in any cycle where the strobe and the enable are both high. They also assume the strobe lasts a single cycle per fault, so each capture is checked against the inputs of the cycle before. The scoreboard drives every input from one task at the falling edge. The task sets every field before it raises the strobe and uses only the four defined access codes, so no property sees undefined data. Some sequences put raw cause words that already carry the store or table bit next to words that do not, which shows that the adjustment is an OR and never a toggle.

// File: rtl/hvf_pkg.sv
package hvf_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'b00,
    EXC_INSTR = 2'b01,
    EXC_DATA  = 2'b10
  } exc_e;

endpackage

// File: rtl/hvf_classify.sv
module hvf_classify #(
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25,
  parameter int TBL_BIT   = 17
) (
  input  logic [1:0]         acc_kind,
  input  logic               tbl_walk,
  input  logic [CAUSE_W-1:0] cause_in,
  output logic               is_fetch,
  output logic               is_store,
  output logic [CAUSE_W-1:0] adj_cause
);
  import hvf_pkg::*;

  localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;
  localparam logic [CAUSE_W-1:0] TBL_MASK   = CAUSE_W'(1) << TBL_BIT;

  // Adjust the raw cause: OR in the marker bits, never clear anything.
  function automatic logic [CAUSE_W-1:0] adjust(
    input logic [CAUSE_W-1:0] raw,
    input logic               st,
    input logic               tb
  );
    logic [CAUSE_W-1:0] v;
    v = raw;
    if (st) v = v | STORE_MASK;
    if (tb) v = v | TBL_MASK;
    return v;
  endfunction

  always_comb begin
    is_fetch  = (acc_kind == ACC_FETCH);
    is_store  = (acc_kind == ACC_WRITE);
    adj_cause = adjust(cause_in, is_store, tbl_walk);
  end

endmodule

// File: rtl/hvf_fold.sv
module hvf_fold #(
  parameter int CAUSE_W = 32,
  parameter int STATE_W = 64
) (
  input  logic [STATE_W-1:0] state_in,
  input  logic [CAUSE_W-1:0] code,
  output logic [STATE_W-1:0] folded
);
  logic [STATE_W-1:0] code_ext;

  generate
    if (STATE_W >= CAUSE_W) begin : g_wide
      assign code_ext = {{(STATE_W-CAUSE_W){1'b0}}, code};
    end else begin : g_narrow
      assign code_ext = code[STATE_W-1:0];
    end
  endgenerate

  assign folded = state_in | code_ext;

endmodule

// File: rtl/hvf_regs.sv
module hvf_regs #(
  parameter int ADDR_W  = 64,
  parameter int CAUSE_W = 32,
  parameter int STATE_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_cap,
  input  logic               data_cap,
  input  logic [CAUSE_W-1:0] adj_cause,
  input  logic [ADDR_W-1:0]  eff_addr,
  input  logic [ADDR_W-1:0]  guest_ra,
  input  logic [STATE_W-1:0] state_in,
  input  logic [STATE_W-1:0] folded_state,
  output logic [1:0]         exc_kind,
  output logic [CAUSE_W-1:0] flt_status,
  output logic [ADDR_W-1:0]  flt_daddr,
  output logic [ADDR_W-1:0]  sec_addr,
  output logic [CAUSE_W-1:0] err_code,
  output logic [STATE_W-1:0] saved_state,
  output logic               fault_evt
);
  import hvf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_kind    <= EXC_NONE;
      flt_status  <= '0;
      flt_daddr   <= '0;
      sec_addr    <= '0;
      err_code    <= '0;
      saved_state <= '0;
      fault_evt   <= 1'b0;
    end else begin
      fault_evt <= instr_cap | data_cap;
      if (instr_cap) begin
        exc_kind    <= EXC_INSTR;
        sec_addr    <= guest_ra;
        err_code    <= adj_cause;
        saved_state <= folded_state;
      end else if (data_cap) begin
        exc_kind    <= EXC_DATA;
        flt_status  <= adj_cause;
        flt_daddr   <= eff_addr;
        sec_addr    <= guest_ra;
        err_code    <= '0;
        saved_state <= state_in;
      end
    end
  end

endmodule

// File: rtl/hvf_fault_capture.sv
module hvf_fault_capture #(
  parameter int ADDR_W    = 64,
  parameter int CAUSE_W   = 32,
  parameter int STATE_W   = 64,
  parameter int STORE_BIT = 25,
  parameter int TBL_BIT   = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_en,
  input  logic               flt_valid,
  input  logic [1:0]         acc_kind,
  input  logic [ADDR_W-1:0]  eff_addr,
  input  logic [ADDR_W-1:0]  guest_ra,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic               tbl_walk,
  input  logic [STATE_W-1:0] state_in,
  output logic [1:0]         exc_kind,
  output logic [CAUSE_W-1:0] flt_status,
  output logic [ADDR_W-1:0]  flt_daddr,
  output logic [ADDR_W-1:0]  sec_addr,
  output logic [CAUSE_W-1:0] err_code,
  output logic [STATE_W-1:0] saved_state,
  output logic               fault_evt
);
  logic               is_fetch;
  logic               is_store;
  logic [CAUSE_W-1:0] adj_cause;
  logic [STATE_W-1:0] folded_state;
  logic               cap_fire;
  logic               instr_cap;
  logic               data_cap;

  assign cap_fire  = flt_valid & cap_en;
  assign instr_cap = cap_fire & is_fetch;
  assign data_cap  = cap_fire & ~is_fetch;

  hvf_classify #(
    .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT), .TBL_BIT(TBL_BIT)
  ) u_classify (
    .acc_kind (acc_kind),
    .tbl_walk (tbl_walk),
    .cause_in (cause_in),
    .is_fetch (is_fetch),
    .is_store (is_store),
    .adj_cause(adj_cause)
  );

  hvf_fold #(.CAUSE_W(CAUSE_W), .STATE_W(STATE_W)) u_fold (
    .state_in(state_in),
    .code    (adj_cause),
    .folded  (folded_state)
  );

  hvf_regs #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .STATE_W(STATE_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .instr_cap   (instr_cap),
    .data_cap    (data_cap),
    .adj_cause   (adj_cause),
    .eff_addr    (eff_addr),
    .guest_ra    (guest_ra),
    .state_in    (state_in),
    .folded_state(folded_state),
    .exc_kind    (exc_kind),
    .flt_status  (flt_status),
    .flt_daddr   (flt_daddr),
    .sec_addr    (sec_addr),
    .err_code    (err_code),
    .saved_state (saved_state),
    .fault_evt   (fault_evt)
  );

endmodule

// File: rtl/hvf_fault_capture_chk.sv
module hvf_fault_capture_chk #(
  parameter int ADDR_W    = 64,
  parameter int CAUSE_W   = 32,
  parameter int STATE_W   = 64,
  parameter int STORE_BIT = 25,
  parameter int TBL_BIT   = 17
) (
  input logic               clk,
  input logic               rst,
  input logic               cap_fire,
  input logic               instr_cap,
  input logic               data_cap,
  input logic [1:0]         acc_kind,
  input logic               tbl_walk,
  input logic [ADDR_W-1:0]  eff_addr,
  input logic [ADDR_W-1:0]  guest_ra,
  input logic [1:0]         exc_kind,
  input logic [CAUSE_W-1:0] flt_status,
  input logic [ADDR_W-1:0]  flt_daddr,
  input logic [ADDR_W-1:0]  sec_addr,
  input logic [CAUSE_W-1:0] err_code,
  input logic [STATE_W-1:0] saved_state,
  input logic               fault_evt
);
  a_r2_instr_secaddr: assert property (@(posedge clk) disable iff (rst)
    instr_cap |=> (exc_kind == 2'b01) && (sec_addr == $past(guest_ra)));

  a_r2_instr_keeps_data: assert property (@(posedge clk) disable iff (rst)
    instr_cap |=> $stable(flt_status) && $stable(flt_daddr));

  a_r4_data_regs: assert property (@(posedge clk) disable iff (rst)
    data_cap |=> (exc_kind == 2'b10) && (flt_daddr == $past(eff_addr))
                 && (sec_addr == $past(guest_ra)));

  a_r5_store_bit: assert property (@(posedge clk) disable iff (rst)
    (cap_fire && acc_kind == 2'b01) |=> flt_status[STORE_BIT]);

  a_r6_tbl_data: assert property (@(posedge clk) disable iff (rst)
    (data_cap && tbl_walk) |=> flt_status[TBL_BIT]);

  a_r6_tbl_instr: assert property (@(posedge clk) disable iff (rst)
    (instr_cap && tbl_walk) |=> err_code[TBL_BIT] && saved_state[TBL_BIT]);

  a_r7_data_err_zero: assert property (@(posedge clk) disable iff (rst)
    data_cap |=> (err_code == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !cap_fire |=> $stable(exc_kind) && $stable(flt_status) && $stable(flt_daddr)
                  && $stable(sec_addr) && $stable(err_code) && $stable(saved_state));

  a_r10_evt: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> fault_evt);

  a_r10_evt_quiet: assert property (@(posedge clk) disable iff (rst)
    !cap_fire |=> !fault_evt);

  a_r2_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({instr_cap, data_cap}));

endmodule

bind hvf_fault_capture hvf_fault_capture_chk #(
  .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .STATE_W(STATE_W),
  .STORE_BIT(STORE_BIT), .TBL_BIT(TBL_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cap_fire   (cap_fire),
  .instr_cap  (instr_cap),
  .data_cap   (data_cap),
  .acc_kind   (acc_kind),
  .tbl_walk   (tbl_walk),
  .eff_addr   (eff_addr),
  .guest_ra   (guest_ra),
  .exc_kind   (exc_kind),
  .flt_status (flt_status),
  .flt_daddr  (flt_daddr),
  .sec_addr   (sec_addr),
  .err_code   (err_code),
  .saved_state(saved_state),
  .fault_evt  (fault_evt)
);

// File: tb/hvf_fault_capture_bench.sv
module hvf_fault_capture_bench;
  localparam int AW = 64;
  localparam int CW = 32;
  localparam int SW = 64;

  typedef struct {
    string          tag;
    logic [1:0]     kind;
    logic [CW-1:0]  fsr;
    logic [AW-1:0]  fdar;
    logic [AW-1:0]  sec;
    logic [CW-1:0]  err;
    logic [SW-1:0]  st;
    logic           evt;
  } snap_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_en = 1'b0;
  logic flt_valid = 1'b0;
  logic [1:0] acc_kind = 2'b00;
  logic [AW-1:0] eff_addr = '0;
  logic [AW-1:0] guest_ra = '0;
  logic [CW-1:0] cause_in = '0;
  logic tbl_walk = 1'b0;
  logic [SW-1:0] state_in = '0;
  logic [1:0] exc_kind;
  logic [CW-1:0] flt_status;
  logic [AW-1:0] flt_daddr;
  logic [AW-1:0] sec_addr;
  logic [CW-1:0] err_code;
  logic [SW-1:0] saved_state;
  logic fault_evt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  snap_t q[$];
  snap_t m;

  always #5 clk = ~clk;

  hvf_fault_capture u_hvf_fault_capture (
    .clk(clk), .rst(rst), .cap_en(cap_en), .flt_valid(flt_valid),
    .acc_kind(acc_kind), .eff_addr(eff_addr), .guest_ra(guest_ra),
    .cause_in(cause_in), .tbl_walk(tbl_walk), .state_in(state_in),
    .exc_kind(exc_kind), .flt_status(flt_status), .flt_daddr(flt_daddr),
    .sec_addr(sec_addr), .err_code(err_code), .saved_state(saved_state),
    .fault_evt(fault_evt)
  );

  task automatic chk(input string tag, input string f, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
    end
  endtask

  // Driver: sets inputs at the falling edge, advances the reference model, queues it.
  task automatic drive(input string tag, input logic r, input logic en, input logic v,
                       input logic [1:0] a, input logic [AW-1:0] ea, input logic [AW-1:0] gra,
                       input logic [CW-1:0] c, input logic tb, input logic [SW-1:0] s);
    logic [CW-1:0] cz;
    @(negedge clk);
    rst = r; cap_en = en; flt_valid = v; acc_kind = a; eff_addr = ea;
    guest_ra = gra; cause_in = c; tbl_walk = tb; state_in = s;
    cz = c | (tb ? 32'h0002_0000 : 32'h0);
    m.tag = tag;
    if (r) begin
      m.kind = 2'b00; m.fsr = '0; m.fdar = '0; m.sec = '0; m.err = '0; m.st = '0; m.evt = 1'b0;
    end else begin
      m.evt = v & en;
      if (v && en && a == 2'b10) begin
        m.kind = 2'b01; m.sec = gra; m.err = cz; m.st = s | {32'h0, cz};
      end else if (v && en) begin
        if (a == 2'b01) cz = cz | 32'h0200_0000;
        m.kind = 2'b10; m.fsr = cz; m.fdar = ea; m.sec = gra; m.err = '0; m.st = s;
      end
    end
    q.push_back(m);
  endtask

  // Monitor: after each rising edge, compares outputs against the queued expectation.
  initial begin
    snap_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "kind", 64'(exc_kind), 64'(e.kind));
        chk(e.tag, "status", 64'(flt_status), 64'(e.fsr));
        chk(e.tag, "daddr", flt_daddr, e.fdar);
        chk(e.tag, "secaddr", sec_addr, e.sec);
        chk(e.tag, "err", 64'(err_code), 64'(e.err));
        chk(e.tag, "state", saved_state, e.st);
        chk(e.tag, "evt", 64'(fault_evt), 64'(e.evt));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m = '{tag:"init", kind:2'b00, fsr:'0, fdar:'0, sec:'0, err:'0, st:'0, evt:1'b0};
    drive("R1 reset", 1, 0, 0, 2'b00, 64'h0, 64'h0, 32'h0, 0, 64'h0);
    drive("R1 reset", 1, 1, 1, 2'b01, 64'h11, 64'h22, 32'h33, 1, 64'h44);
    drive("R8 idle", 0, 1, 0, 2'b01, 64'hAA, 64'hBB, 32'hCC, 1, 64'hDD);
    drive("R2 R3 fetch", 0, 1, 1, 2'b10, 64'h1000_0000_0000_1234, 64'h0000_0000_4567_8000,
          32'h4000_0000, 0, 64'h8000_0000_0000_0001);
    drive("R10 evt drop", 0, 1, 0, 2'b10, 64'h0, 64'h0, 32'h0, 0, 64'h0);
    drive("R4 read", 0, 1, 1, 2'b00, 64'hC000_0000_0000_ABC0, 64'h0000_0001_0000_0000,
          32'h4000_0000, 0, 64'h5);
    drive("R5 write", 0, 1, 1, 2'b01, 64'h7777_0000, 64'h8888_0000, 32'h0800_0000, 0, 64'h6);
    drive("R5 R6 write tbl", 0, 1, 1, 2'b01, 64'h1, 64'h2, 32'h0200_0000, 1, 64'h7);
    drive("R6 R3 fetch tbl", 0, 1, 1, 2'b10, 64'h9, 64'hF000, 32'h0000_0001, 1, 64'hFFFF_0000_0000_0000);
    drive("R9 probe fetch", 0, 0, 1, 2'b10, 64'h5555, 64'h6666, 32'hFFFF_FFFF, 1, 64'h1234);
    drive("R9 probe write", 0, 0, 1, 2'b01, 64'h5555, 64'h6666, 32'hFFFF_FFFF, 1, 64'h1234);
    drive("R7 R4 alt read", 0, 1, 1, 2'b11, 64'hDEAD_BEEF, 64'hFEED_F00D, 32'h0002_0000, 0, 64'h99);
    drive("R6 read tbl", 0, 1, 1, 2'b00, 64'h31, 64'h32, 32'h1, 1, 64'h33);
    drive("R2 fetch keeps data", 0, 1, 1, 2'b10, 64'h41, 64'h42, 32'h0, 0, 64'h0);
    drive("R8 hold", 0, 0, 0, 2'b00, 64'h0, 64'h0, 32'h0, 0, 64'h0);
    for (int i = 0; i < 20; i++) begin
      logic [1:0] a;
      a = 2'(i % 4);
      drive("R4 R2 sweep", 0, (i % 5) != 4, (i % 3) != 2, a, 64'(i * 32'h1111),
            64'(i * 32'h2345), 32'(i) << 16, (i % 2) == 1, 64'(i * 7));
    end
    drive("R1 reset again", 1, 1, 1, 2'b10, 64'h1, 64'h1, 32'h1, 1, 64'h1);
    drive("R8 after reset", 0, 1, 0, 2'b00, 64'h0, 64'h0, 32'h0, 0, 64'h0);
    @(negedge clk);
    flt_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule